// File: doc/BRIEF.md
# Mode-banked UART register decoder

This block decodes register accesses for a 16750-style UART channel. Each access arrives as a command byte and a data byte, qualified by a one-cycle strobe. The command byte carries the read/write direction, a 4-bit register index and a 2-bit channel select. The decoder maps this onto one of 26 physical registers. For a write it raises a one-hot write-enable pulse. For a read it raises a read-valid pulse and a read-multiplexer select code.

Several indices alias onto different registers depending on three things: the line-control register (its top bit, and the special value 0xBF), the enhanced-enable bit of the enhanced feature register, and bit 2 of the modem control register. Because those three registers govern the banking, the block holds them itself and exposes their values. An IO-control write can also reset them at once. The serial engine, the FIFOs and the remaining registers live elsewhere; they act on the enables and the select produced here.

Top module: `mode_banked_regdec`

## Requirements
- R1: Command byte fields: bit 7 = 1 means read and 0 means write; bits [6:3] hold the register index; bits [2:1] select the channel. An access whose channel differs from parameter ChanId (default 0) raises no write enable and no read-valid, and changes no held register.
- R2: The results of a strobe appear one clock edge after the edge that samples it, and last one cycle. A write gives at most one bit set in `wrEn`. A read gives `rdValid` = 1 and a code on `rdSel`. Without a strobe, `wrEn` is 0, `rdValid` is 0 and `rdSel` is 0.
- R3: Physical register codes, which are also the bit positions in `wrEn`: 0 none, 1 receive buffer, 2 transmit holding, 3 interrupt enable, 4 divisor low, 5 divisor high, 6 interrupt id, 7 FIFO control, 8 enhanced feature, 9 line control, 10 modem control, 11 line status, 12 modem status, 13 scratch, 14 transmission control, 15 trigger level, 16 XON1, 17 XON2, 18 XOFF1, 19 XOFF2, 20 TX level, 21 RX level, 22 GPIO direction, 23 GPIO state, 24 GPIO interrupt enable, 25 IO control, 26 extra features.
- R4: Indices 0 and 1 depend on line-control bit 7. When it is 1, they reach divisor low and divisor high. When it is 0, index 0 is the receive buffer on read and transmit holding on write, and index 1 is interrupt enable.
- R5: Index 2 is interrupt id on read and FIFO control on write, unless line control equals 0xBF. In that case index 2 is the enhanced feature register for both directions.
- R6: While line control equals 0xBF, indices 4, 5, 6 and 7 reach XON1, XON2, XOFF1 and XOFF2.
- R7: Otherwise, indices 6 and 7 reach transmission control and trigger level when enhanced-feature bit 4 and modem-control bit 2 are both 1. If not, they reach modem status (read only) and scratch.
- R8: Outside the 0xBF bank, index 4 is modem control and index 5 is line status (read only). Index 3 is always line control. Indices 8 to 0xF map to TX level (read only), RX level (read only), GPIO direction, GPIO state, GPIO interrupt enable, reserved, IO control and extra features.
- R9: A write to a read-only or reserved index gives an all-zero `wrEn`. A read of a reserved index gives `rdValid` = 1 with `rdSel` = 0, which means data 0x00.
- R10: A modem-control write changes bits [7:5] and bit 2 only while enhanced-feature bit 4 is 1. The other bits are always written.
- R11: A write to IO control with data bit 3 set still pulses enable bit 25. After that same edge, line control is 0x1D and enhanced feature and modem control are 0x00. The write with bit 3 clear leaves them unchanged.
- R12: After reset, line control is 0x1D, enhanced feature is 0x00 and modem control is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| strobe | input | 1 | Access qualifier, one cycle per access |
| cmdByte | input | 8 | Command byte: direction, index, channel |
| wrData | input | 8 | Write data |
| wrEn | output | 27 | One-hot write enable per physical register code |
| rdValid | output | 1 | Read access pulse |
| rdSel | output | 5 | Read multiplexer select (register code) |
| lcrVal | output | 8 | Held line-control value |
| efrVal | output | 8 | Held enhanced-feature value |
| mcrVal | output | 8 | Held modem-control value |

## Verification
Every result of this block is due exactly one clock edge after the edge that samples the strobe. That includes the enable pulse, the read select and any change to the held banking registers. The bench raises the strobe at a falling edge, drops it at the next falling edge, and samples all outputs at that same moment, half a period after the capturing edge. A vector that changes the banking mode is therefore already in effect for the next vector. Read-only, reserved and wrong-channel accesses are judged by the all-zero enable vector and the unchanged register values in that same sampling slot.

// File: rtl/regdec_pkg.sv
package regdec_pkg;
  localparam int NumRegs = 27;
  localparam int SelW = $clog2(NumRegs);

  typedef enum logic [SelW-1:0] {
    RC_NONE      = 5'd0,
    RC_RXBUF     = 5'd1,
    RC_TXHOLD    = 5'd2,
    RC_INTEN     = 5'd3,
    RC_DIVLO     = 5'd4,
    RC_DIVHI     = 5'd5,
    RC_INTID     = 5'd6,
    RC_FIFOCTL   = 5'd7,
    RC_ENHFEAT   = 5'd8,
    RC_LINECTL   = 5'd9,
    RC_MODEMCTL  = 5'd10,
    RC_LINESTAT  = 5'd11,
    RC_MODEMSTAT = 5'd12,
    RC_SCRATCH   = 5'd13,
    RC_XMITCTL   = 5'd14,
    RC_TRIGLVL   = 5'd15,
    RC_XON1      = 5'd16,
    RC_XON2      = 5'd17,
    RC_XOFF1     = 5'd18,
    RC_XOFF2     = 5'd19,
    RC_TXLEVEL   = 5'd20,
    RC_RXLEVEL   = 5'd21,
    RC_IODIR     = 5'd22,
    RC_IOSTATE   = 5'd23,
    RC_IOINTEN   = 5'd24,
    RC_IOCTL     = 5'd25,
    RC_EXTFEAT   = 5'd26
  } regCodeE;

  typedef struct packed {
    logic       lcrWr;
    logic       efrWr;
    logic       mcrWr;
    logic       swRst;
    logic [7:0] data;
  } bankStrbS;
endpackage

// File: rtl/regdec_ctrl.sv
module regdec_ctrl
  import regdec_pkg::*;
#(
  parameter logic [1:0] ChanId   = 2'd0,
  parameter int         SwRstBit = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                strobe,
  input  logic [7:0]          cmdByte,
  input  logic [7:0]          wrData,
  input  logic [7:0]          lcrQ,
  input  logic [7:0]          efrQ,
  input  logic [7:0]          mcrQ,
  output bankStrbS            strb,
  output logic [NumRegs-1:0]  wrEn,
  output logic                rdValid,
  output logic [SelW-1:0]     rdSel
);
  logic       isRd;
  logic [3:0] idx;
  logic       hit;
  logic       wrHit;
  logic       divBank;
  logic       xBank;
  logic       tcrOn;
  regCodeE    code;
  logic [NumRegs-1:0] wrEnNext;
  logic       unusedCmdBit;

  assign unusedCmdBit = cmdByte[0];
  assign isRd    = cmdByte[7];
  assign idx     = cmdByte[6:3];
  assign hit     = strobe && (cmdByte[2:1] == ChanId);
  assign wrHit   = hit && !isRd;
  assign divBank = lcrQ[7];
  assign xBank   = (lcrQ == 8'hBF);
  assign tcrOn   = efrQ[4] && mcrQ[2];

  // index -> physical register, banked on the held control state
  always_comb begin
    code = RC_NONE;
    case (idx)
      4'h0: code = divBank ? RC_DIVLO : (isRd ? RC_RXBUF : RC_TXHOLD);
      4'h1: code = divBank ? RC_DIVHI : RC_INTEN;
      4'h2: code = xBank ? RC_ENHFEAT : (isRd ? RC_INTID : RC_FIFOCTL);
      4'h3: code = RC_LINECTL;
      4'h4: code = xBank ? RC_XON1 : RC_MODEMCTL;
      4'h5: code = xBank ? RC_XON2 : (isRd ? RC_LINESTAT : RC_NONE);
      4'h6: code = xBank ? RC_XOFF1 :
                   (tcrOn ? RC_XMITCTL : (isRd ? RC_MODEMSTAT : RC_NONE));
      4'h7: code = xBank ? RC_XOFF2 : (tcrOn ? RC_TRIGLVL : RC_SCRATCH);
      4'h8: code = isRd ? RC_TXLEVEL : RC_NONE;
      4'h9: code = isRd ? RC_RXLEVEL : RC_NONE;
      4'hA: code = RC_IODIR;
      4'hB: code = RC_IOSTATE;
      4'hC: code = RC_IOINTEN;
      4'hE: code = RC_IOCTL;
      4'hF: code = RC_EXTFEAT;
      default: code = RC_NONE;
    endcase
  end

  // strobes toward the held banking registers
  always_comb begin
    strb.lcrWr = wrHit && (code == RC_LINECTL);
    strb.efrWr = wrHit && (code == RC_ENHFEAT);
    strb.mcrWr = wrHit && (code == RC_MODEMCTL);
    strb.swRst = wrHit && (code == RC_IOCTL) && wrData[SwRstBit];
    strb.data  = wrData;
  end

  // code 0 means "no register", so its enable bit stays low
  assign wrEnNext[0] = 1'b0;
  for (genvar g = 1; g < NumRegs; g++) begin : gEn
    assign wrEnNext[g] = wrHit && (code == regCodeE'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrEn    <= '0;
      rdValid <= 1'b0;
      rdSel   <= '0;
    end else begin
      wrEn    <= wrEnNext;
      rdValid <= hit && isRd;
      rdSel   <= (hit && isRd) ? code : RC_NONE;
    end
  end

  AST_WREN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrEn)); // R2
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (wrEn == '0)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |=> (wrEn == '0 && !rdValid && rdSel == '0)); // R2
  AST_CHAN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && cmdByte[2:1] != ChanId) |=> (wrEn == '0 && !rdValid)); // R1
  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe && !cmdByte[7] && (cmdByte[6:3] == 4'h8 || cmdByte[6:3] == 4'h9
     || cmdByte[6:3] == 4'hD)) |=> (wrEn == '0)); // R9
endmodule

// File: rtl/regdec_bank.sv
module regdec_bank
  import regdec_pkg::*;
#(
  parameter logic [7:0] LcrReset = 8'h1D
) (
  input  logic       clk,
  input  logic       rstN,
  input  bankStrbS   strb,
  output logic [7:0] lcrQ,
  output logic [7:0] efrQ,
  output logic [7:0] mcrQ
);
  localparam logic [7:0] McrLockMask = 8'hE4;
  logic [7:0] mcrNext;

  // protected bits keep their value unless the enhanced bit is open
  assign mcrNext = efrQ[4] ? strb.data
                           : ((mcrQ & McrLockMask) | (strb.data & ~McrLockMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lcrQ <= LcrReset;
      efrQ <= 8'h00;
      mcrQ <= 8'h00;
    end else if (strb.swRst) begin
      lcrQ <= LcrReset;
      efrQ <= 8'h00;
      mcrQ <= 8'h00;
    end else begin
      if (strb.lcrWr) lcrQ <= strb.data;
      if (strb.efrWr) efrQ <= strb.data;
      if (strb.mcrWr) mcrQ <= mcrNext;
    end
  end

  AST_MCR_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mcrWr && !efrQ[4] && !strb.swRst)
      |=> (mcrQ[7:5] == $past(mcrQ[7:5]) && mcrQ[2] == $past(mcrQ[2]))); // R10
  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.swRst |=> (lcrQ == LcrReset && efrQ == 8'h00 && mcrQ == 8'h00)); // R11
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.lcrWr && !strb.swRst) |=> $stable(lcrQ)); // R1
endmodule

// File: rtl/mode_banked_regdec.sv
module mode_banked_regdec
  import regdec_pkg::*;
#(
  parameter logic [1:0] ChanId   = 2'd0,
  parameter logic [7:0] LcrReset = 8'h1D,
  parameter int         SwRstBit = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    strobe,
  input  logic [7:0]              cmdByte,
  input  logic [7:0]              wrData,
  output logic [NumRegs-1:0]      wrEn,
  output logic                    rdValid,
  output logic [SelW-1:0]         rdSel,
  output logic [7:0]              lcrVal,
  output logic [7:0]              efrVal,
  output logic [7:0]              mcrVal
);
  bankStrbS strb;

  regdec_ctrl #(.ChanId(ChanId), .SwRstBit(SwRstBit)) ctrl_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdByte(cmdByte),
    .wrData(wrData), .lcrQ(lcrVal), .efrQ(efrVal), .mcrQ(mcrVal),
    .strb(strb), .wrEn(wrEn), .rdValid(rdValid), .rdSel(rdSel)
  );

  regdec_bank #(.LcrReset(LcrReset)) bank_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .lcrQ(lcrVal), .efrQ(efrVal), .mcrQ(mcrVal)
  );
endmodule

// File: tb/mode_banked_regdec_tb.sv
module mode_banked_regdec_tb_top;
  localparam int ClkPeriod = 10;
  localparam int NumVec = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strobe = 1'b0;
  logic [7:0]  cmdByte = 8'h00;
  logic [7:0]  wrData = 8'h00;
  logic [26:0] wrEn;
  logic        rdValid;
  logic [4:0]  rdSel;
  logic [7:0]  lcrVal, efrVal, mcrVal;

  int checks = 0;
  int fails = 0;

  always #(ClkPeriod/2) clk = ~clk;

  mode_banked_regdec dut_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdByte(cmdByte),
    .wrData(wrData), .wrEn(wrEn), .rdValid(rdValid), .rdSel(rdSel),
    .lcrVal(lcrVal), .efrVal(efrVal), .mcrVal(mcrVal)
  );

  // {command, data, expected register code}
  localparam logic [20:0] VecTab [0:NumVec-1] = '{
    {8'h00, 8'h11, 5'd2},   // R4 write idx0, divisor bank off
    {8'h80, 8'h00, 5'd1},   // R4 read idx0
    {8'h08, 8'h00, 5'd3},   // R4 idx1
    {8'h90, 8'h00, 5'd6},   // R5 read idx2
    {8'h10, 8'h00, 5'd7},   // R5 write idx2
    {8'hA8, 8'h00, 5'd11},  // R8 read idx5
    {8'h28, 8'h00, 5'd0},   // R9 write read-only idx5
    {8'hB0, 8'h00, 5'd12},  // R7 read idx6, no tcr
    {8'h38, 8'h00, 5'd13},  // R7 write idx7, no tcr
    {8'h40, 8'h00, 5'd0},   // R9 write TX level
    {8'hC8, 8'h00, 5'd21},  // R8 read idx9
    {8'hE8, 8'h00, 5'd0},   // R9 read reserved
    {8'h68, 8'h00, 5'd0},   // R9 write reserved
    {8'h50, 8'h00, 5'd22},  // R8 idxA
    {8'hF8, 8'h00, 5'd26},  // R8 idxF
    {8'h18, 8'h83, 5'd9},   // R8 line control, divisor bank on
    {8'h00, 8'h00, 5'd4},   // R4 divisor low
    {8'h88, 8'h00, 5'd5},   // R4 divisor high
    {8'h90, 8'h00, 5'd6},   // R5 not 0xBF yet
    {8'h20, 8'h00, 5'd10},  // R8 modem control
    {8'h18, 8'hBF, 5'd9},   // R6 enter 0xBF bank
    {8'h10, 8'h10, 5'd8},   // R5 write enhanced feature
    {8'h90, 8'h00, 5'd8},   // R5 read enhanced feature
    {8'h20, 8'h00, 5'd16},  // R6 XON1
    {8'hB8, 8'h00, 5'd19},  // R6 XOFF2
    {8'h80, 8'h00, 5'd4},   // R4 lcr7 still set
    {8'h18, 8'h03, 5'd9},   // R8 leave 0xBF bank
    {8'h20, 8'h04, 5'd10},  // R10 modem ctl with bit2 (unlocked)
    {8'hB0, 8'h00, 5'd14},  // R7 transmission control
    {8'h38, 8'h00, 5'd15},  // R7 trigger level
    {8'h28, 8'h00, 5'd0},   // R9 line status write
    {8'hA0, 8'h00, 5'd10}   // R8 read modem control
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // strobe for one cycle; outputs sampled at the next falling edge
  task automatic access(input logic [7:0] cmd, input logic [7:0] dat);
    @(negedge clk);
    cmdByte = cmd;
    wrData  = dat;
    strobe  = 1'b1;
    @(negedge clk);
    strobe  = 1'b0;
  endtask

  task automatic expectCode(input logic [7:0] cmd, input logic [4:0] code, input string req);
    logic [26:0] expWr;
    expWr = (!cmd[7] && code != 5'd0) ? (27'd1 << code) : 27'd0;
    check(wrEn == expWr, req, int'(wrEn), int'(expWr));
    check(rdValid == cmd[7], req, int'(rdValid), int'(cmd[7]));
    check(rdSel == (cmd[7] ? code : 5'd0), req, int'(rdSel), int'(cmd[7] ? code : 5'd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset values, R2 quiet outputs
    check(lcrVal == 8'h1D, "R12", int'(lcrVal), 'h1D);
    check(efrVal == 8'h00, "R12", int'(efrVal), 0);
    check(mcrVal == 8'h00, "R12", int'(mcrVal), 0);
    check(wrEn == 27'd0 && !rdValid && rdSel == 5'd0, "R2", int'(wrEn), 0);

    for (int i = 0; i < NumVec; i++) begin
      access(VecTab[i][20:13], VecTab[i][12:5]);
      expectCode(VecTab[i][20:13], VecTab[i][4:0], $sformatf("R3 vec%0d", i));
    end

    // R2 one-cycle pulse: next cycle quiet again
    @(negedge clk);
    check(wrEn == 27'd0 && !rdValid && rdSel == 5'd0, "R2", int'(wrEn), 0);
    // R10 unlocked write took bit2
    check(mcrVal == 8'h04, "R10", int'(mcrVal), 'h04);
    check(efrVal == 8'h10, "R5", int'(efrVal), 'h10);

    // R1 channel mismatch: channel 1 write to line control
    access(8'h1A, 8'h55);
    check(wrEn == 27'd0 && !rdValid, "R1", int'(wrEn), 0);
    check(lcrVal == 8'h03, "R1", int'(lcrVal), 'h03);
    access(8'h82, 8'h00); // channel 1 read
    check(!rdValid && rdSel == 5'd0, "R1", int'(rdValid), 0);

    // R10 lock: clear enhanced bit, then write 0xFF to modem control
    access(8'h18, 8'hBF);
    access(8'h10, 8'h00);
    access(8'h18, 8'h03);
    access(8'h20, 8'hFF);
    check(mcrVal == 8'h1F, "R10", int'(mcrVal), 'h1F);
    // R7 bit2 set but enhanced bit clear -> modem status
    access(8'hB0, 8'h00);
    expectCode(8'hB0, 5'd12, "R7");

    // R11 soft reset bit clear: no effect
    access(8'h18, 8'hBF);
    access(8'h10, 8'h10);
    access(8'h18, 8'h03);
    access(8'h70, 8'h04);
    expectCode(8'h70, 5'd25, "R11");
    check(lcrVal == 8'h03 && efrVal == 8'h10, "R11", int'(lcrVal), 'h03);
    // R11 soft reset bit set
    access(8'h70, 8'h08);
    expectCode(8'h70, 5'd25, "R11");
    check(lcrVal == 8'h1D, "R11", int'(lcrVal), 'h1D);
    check(efrVal == 8'h00, "R11", int'(efrVal), 0);
    check(mcrVal == 8'h00, "R11", int'(mcrVal), 0);
    // R4 after soft reset, divisor bank closed again
    access(8'h08, 8'h00);
    expectCode(8'h08, 5'd3, "R4");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule